// File: doc/BRIEF.md
# Register-Window SPI Master

This block puts a small SPI master behind a 16-bit processor bus. It sits in a window of word registers near the top of a ROM address range. A signature word written to one register unlocks it, and any other value written there locks it again. While it is locked, every address in the window returns the ROM word presented on `rom_data`, and writes to the window do nothing except at the signature register.

Once the block is unlocked, software can drive the card in two ways. It can toggle select, clock and data one level at a time through a control register and sample the data-in line from a status register. It can also hand a byte to a hardware shifter, which clocks eight bits in SPI mode 0 at a fixed fast rate. Reading the receive-and-shift alias returns the byte just captured and starts the next 8-bit shift with all-ones data, so a stream of bytes can be read with one read per byte. While the shifter is busy, any access to the window is stalled through `bus_wait` until the shift ends.

Top module: `romwin_spi_master`

## Requirements
- R1: After reset the block is locked, `spi_cs_n` is 1, `spi_sck` is 0, `spi_mosi` is 0 and `bus_wait` is 0.
- R2: A write of 0xC1AD to byte address base+0x20 (base = 0x41FFC0) unlocks the block, and a write of any other value there locks it. While locked, and at any address outside base+0x10..base+0x23, `bus_rdata` equals `rom_data`.
- R3: While the block is locked, writes to the control, transmit and transmit-shift registers change no SPI pin and start no clock pulses.
- R4: A write to the control register (base+0x18) sets chip select active when bit 15 is 1 (`spi_cs_n` = 0) and drives `spi_sck` to the level of bit 14.
- R5: A read of the status register (base+0x10) returns bit 15 = select, bit 14 = clock level written to control, bit 13 = the current `spi_miso` level, and all other bits 0.
- R6: A write to the plain transmit register (base+0x1A) drives `spi_mosi` from bit 15 of the word and produces no `spi_sck` edge.
- R7: A write to the transmit-shift register (base+0x1C) shifts bits 7..0 out MSB first over 8 SCK pulses in mode 0 (MOSI changes while SCK is low, MISO is sampled on the rising edge). Each SCK half period lasts SCK_HALF clocks, so a shift takes 16*SCK_HALF cycles.
- R8: A read of the receive register (base+0x12) returns in bits 7..0 the byte last captured by a hardware shift, with bits 15..8 zero. A read of the receive-shift alias (base+0x14) returns the same value and then starts a shift that sends 0xFF.
- R9: While a hardware shift runs, any read or write to the window holds `bus_wait` high until the shift ends. Accesses outside the window are never stalled.
- R10: When a hardware shift ends, `spi_sck` returns low and `spi_mosi` returns to the level last set through the transmit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the bus access |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write request, held until accepted |
| bus_rd | input | 1 | Read request, held until accepted |
| rom_data | input | 16 | Word from the ROM at bus_addr |
| bus_rdata | output | 16 | Read data, valid in the accepting cycle |
| bus_wait | output | 1 | Stall for the current access |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Data to the card |
| spi_miso | input | 1 | Data from the card |

## Verification
If the shifter's bit count or phase is off, the card model sees a wrong number of SCK pulses or a byte shifted by one bit, and the receive register shows the error on the very next read. If the stall window is wrong, the number of wait cycles on the access that follows a shift differs from 16*SCK_HALF, and a read taken too early returns the previous byte. If the enable flag is corrupted, a locked-mode write moves `spi_cs_n`, or a window read returns register data instead of the ROM word within one access.

// File: rtl/romwin_spi_pkg.sv
package romwin_spi_pkg;

    localparam logic [15:0] SIG_KEY = 16'hC1AD;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_STAT,
        REG_RX,
        REG_RXSH,
        REG_CTL,
        REG_TX,
        REG_TXSH,
        REG_SIG
    } reg_sel_e;

    typedef struct packed {
        logic sel;
        logic clk;
        logic mosi;
    } bb_state_t;

    function automatic reg_sel_e decode_offset(input logic [5:0] off);
        case ({off[5:1], 1'b0})
            6'h10:   return REG_STAT;
            6'h12:   return REG_RX;
            6'h14:   return REG_RXSH;
            6'h18:   return REG_CTL;
            6'h1A:   return REG_TX;
            6'h1C:   return REG_TXSH;
            6'h20:   return REG_SIG;
            default: return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/romwin_decode.sv
module romwin_decode
    import romwin_spi_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(24'h41FFC0)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output reg_sel_e          sel
);
    localparam int PAGE_LSB = 6;

    logic [5:0] off;
    logic       page_hit;

    assign off      = addr[PAGE_LSB-1:0];
    assign page_hit = (addr[ADDR_W-1:PAGE_LSB] == WIN_BASE[ADDR_W-1:PAGE_LSB]);
    assign in_win   = page_hit && (off >= 6'h10) && (off <= 6'h23);
    assign sel      = in_win ? decode_offset(off) : REG_NONE;

endmodule

// File: rtl/romwin_spi_shifter.sv
module romwin_spi_shifter #(
    parameter int SCK_HALF = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_next
);
    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);

    logic             busy_q;
    logic             sck_q;
    logic             cap_q;
    logic [7:0]       sh_q;
    logic [2:0]       bit_q;
    logic [DIV_W-1:0] div_q;
    logic             tick;

    assign tick    = (div_q == DIV_LAST);
    assign busy    = busy_q;
    assign sck     = sck_q;
    assign mosi    = sh_q[7];
    assign rx_next = {sh_q[6:0], cap_q};
    assign done    = busy_q && tick && sck_q && (bit_q == 3'd7);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            cap_q  <= 1'b0;
            sh_q   <= '0;
            bit_q  <= '0;
            div_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                sck_q  <= 1'b0;
                sh_q   <= tx_byte;
                bit_q  <= '0;
                div_q  <= '0;
            end
        end else if (tick) begin
            div_q <= '0;
            if (!sck_q) begin
                sck_q <= 1'b1;
                cap_q <= miso;
            end else begin
                sck_q <= 1'b0;
                sh_q  <= {sh_q[6:0], cap_q};
                if (bit_q == 3'd7) busy_q <= 1'b0;
                else               bit_q  <= bit_q + 3'd1;
            end
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // R7: exactly eight bits are shifted before the engine goes idle
    a_r7_eight_bits: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> $past(bit_q) == 3'd7);

    // R10: the shift clock is low whenever the engine is idle
    a_r10_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && $past(!busy_q)) |-> !sck_q);

endmodule

// File: rtl/romwin_spi_master.sv
module romwin_spi_master
    import romwin_spi_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(24'h41FFC0),
    parameter int SCK_HALF = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [15:0]       rom_data,
    output logic [15:0]       bus_rdata,
    output logic              bus_wait,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic      in_win;
    reg_sel_e  sel;
    logic      en_q;
    bb_state_t bb_q;
    logic [7:0] rx_q;
    logic      win_hit, acc_wr, acc_rd;
    logic      sig_wr, sh_start;
    logic [7:0] sh_tx;
    logic      sh_busy, sh_sck, sh_mosi, sh_done;
    logic [7:0] sh_rx;

    romwin_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
        .addr(bus_addr), .in_win(in_win), .sel(sel)
    );

    romwin_spi_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk(clk), .rst(rst), .start(sh_start), .tx_byte(sh_tx),
        .miso(spi_miso), .busy(sh_busy), .sck(sh_sck), .mosi(sh_mosi),
        .done(sh_done), .rx_next(sh_rx)
    );

    assign win_hit  = in_win && en_q;
    assign bus_wait = (bus_wr || bus_rd) && win_hit && sh_busy;
    assign acc_wr   = bus_wr && !bus_wait;
    assign acc_rd   = bus_rd && !bus_wait;
    assign sig_wr   = acc_wr && (sel == REG_SIG);
    assign sh_start = win_hit && ((acc_wr && sel == REG_TXSH) ||
                                  (acc_rd && sel == REG_RXSH));
    assign sh_tx    = (bus_wr && sel == REG_TXSH) ? bus_wdata[7:0] : 8'hFF;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            bb_q <= '0;
            rx_q <= '0;
        end else begin
            if (sig_wr) en_q <= (bus_wdata == SIG_KEY);
            if (acc_wr && win_hit && sel == REG_CTL) begin
                bb_q.sel <= bus_wdata[15];
                bb_q.clk <= bus_wdata[14];
            end
            if (acc_wr && win_hit && sel == REG_TX) bb_q.mosi <= bus_wdata[15];
            if (sh_done) rx_q <= sh_rx;
        end
    end

    always_comb begin
        bus_rdata = rom_data;
        if (win_hit) begin
            case (sel)
                REG_STAT:        bus_rdata = {bb_q.sel, bb_q.clk, spi_miso, 13'h0};
                REG_RX, REG_RXSH: bus_rdata = {8'h00, rx_q};
                default:         bus_rdata = rom_data;
            endcase
        end
    end

    assign spi_cs_n = !bb_q.sel;
    assign spi_sck  = sh_busy ? sh_sck  : bb_q.clk;
    assign spi_mosi = sh_busy ? sh_mosi : bb_q.mosi;

    // R2: the signature value unlocks, any other value locks
    a_r2_sig_unlocks: assert property (@(posedge clk) disable iff (rst)
        (sig_wr && bus_wdata == SIG_KEY) |=> en_q);
    a_r2_other_locks: assert property (@(posedge clk) disable iff (rst)
        (sig_wr && bus_wdata != SIG_KEY) |=> !en_q);

    // R3: while locked the select line and shifter do not move
    a_r3_locked_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(en_q) |-> ($stable(spi_cs_n) && !$rose(sh_busy)));

    // R9: a stall only happens while a shift is running
    a_r9_wait_needs_busy: assert property (@(posedge clk) disable iff (rst)
        bus_wait |-> sh_busy);

    // R7: MOSI holds while SCK is high during a hardware shift
    a_r7_mosi_hold_high: assert property (@(posedge clk) disable iff (rst)
        (sh_busy && $past(sh_busy) && spi_sck) |-> $stable(spi_mosi));

endmodule

// File: tb/sim_romwin_spi_master.sv
module sim_romwin_spi_master;
    localparam logic [23:0] BASE = 24'h41FFC0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] rom_data, bus_rdata;
    logic        bus_wait, spi_cs_n, spi_sck, spi_mosi, spi_miso;

    int n_cmp = 0, n_mis = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign rom_data = bus_addr[15:0] ^ 16'hBEEF;

    romwin_spi_master u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .rom_data(rom_data),
        .bus_rdata(bus_rdata), .bus_wait(bus_wait), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // card model: mode 0, MSB first, byte-framed
    function automatic logic [7:0] pat(input int i);
        return 8'hA5 ^ 8'(i * 29);
    endfunction

    logic [7:0] s_out = 8'h00, s_in = 8'h00;
    int s_cnt = 0, s_idx = 0, rise_cnt = 0;
    logic [7:0] got_q[$];

    typedef struct { logic [7:0] b; string req; } exp_t;
    exp_t exp_q[$];

    assign spi_miso = spi_cs_n ? 1'b1 : s_out[7];

    always @(negedge spi_cs_n) begin
        s_out = pat(s_idx);
        s_cnt = 0;
    end
    always @(posedge spi_sck) begin
        rise_cnt++;
        if (spi_cs_n === 1'b0) begin
            s_in = {s_in[6:0], spi_mosi};
            s_cnt++;
        end
    end
    always @(negedge spi_sck) begin
        if (spi_cs_n === 1'b0) begin
            if (s_cnt == 8) begin
                got_q.push_back(s_in);
                s_idx++;
                s_out = pat(s_idx);
                s_cnt = 0;
            end else begin
                s_out = {s_out[6:0], 1'b0};
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: bytes seen by the card vs expected bytes
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                logic [7:0] g;
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk("R7", "unexpected byte at card", {24'h0, g}, 32'hFFFF_FFFF);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(e.req, "byte at card", {24'h0, g}, {24'h0, e.b});
                end
            end
        end
    end

    task automatic acc(input logic [23:0] a, input logic wr, input logic [15:0] d,
                       output logic [15:0] q, output int waits);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = !wr;
        waits = 0;
        #1;
        while (bus_wait) begin
            waits++;
            @(negedge clk);
            #1;
        end
        q = bus_rdata;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr16(input logic [7:0] off, input logic [15:0] d);
        logic [15:0] q; int w;
        acc(BASE + 24'(off), 1'b1, d, q, w);
    endtask

    task automatic rd16(input logic [7:0] off, output logic [15:0] q);
        int w;
        acc(BASE + 24'(off), 1'b0, 16'h0, q, w);
    endtask

    initial begin
        logic [15:0] q;
        int w, r0;
        logic [7:0] bb_rx, tx, last_rx;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "cs_n after reset", {31'h0, spi_cs_n}, 32'h1);
        chk("R1", "sck after reset", {31'h0, spi_sck}, 32'h0);
        chk("R1", "mosi after reset", {31'h0, spi_mosi}, 32'h0);
        chk("R1", "wait after reset", {31'h0, bus_wait}, 32'h0);

        // R2 locked window reads ROM
        rd16(8'h10, q);
        chk("R2", "locked status read", {16'h0, q}, {16'h0, (BASE[15:0] + 16'h10) ^ 16'hBEEF});

        // R3 locked writes have no effect
        r0 = rise_cnt;
        wr16(8'h18, 16'hC000);
        wr16(8'h1C, 16'h0055);
        repeat (20) @(negedge clk);
        chk("R3", "cs_n after locked control write", {31'h0, spi_cs_n}, 32'h1);
        chk("R3", "sck edges after locked writes", rise_cnt - r0, 0);

        // R2 wrong signature keeps it locked
        wr16(8'h20, 16'h1234);
        rd16(8'h12, q);
        chk("R2", "read after wrong key", {16'h0, q}, {16'h0, (BASE[15:0] + 16'h12) ^ 16'hBEEF});

        // R2 unlock, R5 status with card deselected
        wr16(8'h20, 16'hC1AD);
        rd16(8'h10, q);
        chk("R5", "status while deselected", {16'h0, q}, 32'h2000);

        // R4 select
        wr16(8'h18, 16'h8000);
        @(negedge clk);
        chk("R4", "cs_n after select", {31'h0, spi_cs_n}, 32'h0);
        chk("R4", "sck after select", {31'h0, spi_sck}, 32'h0);
        rd16(8'h10, q);
        chk("R5", "status after select", {16'h0, q}, {16'h0, 16'h8000 | (16'(pat(0)[7]) << 13)});

        // R4/R5/R6 bit-banged byte
        tx = 8'h5B;
        exp_q.push_back('{tx, "R6"});
        bb_rx = 8'h00;
        wr16(8'h1A, {tx[7], 15'h0});
        for (int i = 0; i < 8; i++) begin
            rd16(8'h10, q);
            bb_rx = {bb_rx[6:0], q[13]};
            wr16(8'h18, 16'hC000);
            if (i == 0) chk("R4", "sck high after control write", {31'h0, spi_sck}, 32'h1);
            wr16(8'h18, 16'h8000);
            if (i < 7) wr16(8'h1A, 16'(tx << (i + 9)) & 16'h8000);
        end
        chk("R5", "bit-banged received byte", {24'h0, bb_rx}, {24'h0, pat(0)});

        // R6 plain transmit: no clocks, MOSI from bit 15
        r0 = rise_cnt;
        wr16(8'h1A, 16'h8000);
        @(negedge clk);
        chk("R6", "mosi after 0x8000", {31'h0, spi_mosi}, 32'h1);
        wr16(8'h1A, 16'h7FFF);
        @(negedge clk);
        chk("R6", "mosi after 0x7FFF", {31'h0, spi_mosi}, 32'h0);
        chk("R6", "sck edges from plain writes", rise_cnt - r0, 0);

        // R7/R9 hardware shift and stall
        r0 = rise_cnt;
        exp_q.push_back('{8'h3C, "R7"});
        wr16(8'h1C, 16'hAB3C);
        acc(BASE + 24'h12, 1'b0, 16'h0, q, w);
        chk("R9", "stall cycles after shift", w, 16);
        chk("R8", "receive after shift", {16'h0, q}, {24'h0, pat(1)});
        chk("R7", "sck pulses per shift", rise_cnt - r0, 8);
        @(negedge clk);
        chk("R10", "sck low after shift", {31'h0, spi_sck}, 32'h0);
        chk("R10", "mosi back to bit-bang level", {31'h0, spi_mosi}, 32'h0);
        last_rx = pat(1);

        // R8 streamed reads via the receive-shift alias
        for (int k = 0; k < 3; k++) begin
            exp_q.push_back('{8'hFF, "R8"});
            rd16(8'h14, q);
            chk("R8", "receive-shift returns previous byte", {16'h0, q}, {24'h0, last_rx});
            last_rx = pat(2 + k);
        end
        rd16(8'h12, q);
        chk("R8", "receive after streamed shift", {16'h0, q}, {24'h0, last_rx});

        // R9 accesses outside the window are not stalled
        exp_q.push_back('{8'hC3, "R7"});
        wr16(8'h1C, 16'h00C3);
        acc(24'h400000, 1'b0, 16'h0, q, w);
        chk("R9", "outside access wait cycles", w, 0);
        chk("R2", "outside access returns ROM", {16'h0, q}, {16'h0, 16'h0000 ^ 16'hBEEF});
        acc(BASE + 24'h10, 1'b0, 16'h0, q, w);
        chk("R9", "window access stalled during shift", {31'h0, (w > 0)}, 32'h1);

        // R2/R3 lock again: control write ignored, window is ROM
        wr16(8'h20, 16'h0000);
        wr16(8'h18, 16'h0000);
        @(negedge clk);
        chk("R3", "cs_n held after locked deselect", {31'h0, spi_cs_n}, 32'h0);
        rd16(8'h12, q);
        chk("R2", "locked receive read", {16'h0, q}, {16'h0, (BASE[15:0] + 16'h12) ^ 16'hBEEF});
        wr16(8'h20, 16'hC1AD);
        wr16(8'h18, 16'h0000);
        @(negedge clk);
        chk("R4", "cs_n after deselect", {31'h0, spi_cs_n}, 32'h1);

        repeat (4) @(negedge clk);
        chk("R7", "pending expected bytes", exp_q.size(), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_mis++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

endmodule